// File: doc/BRIEF.md
# Section DCC Serial Byte Inserter

This block sits in the byte-wide transmit path of an STS-3c/STM-1 framer. It takes in the section data communication channel as a serial bit stream and writes it into the three section DCC bytes of every frame. The upstream serial source is paced by a gapped strobe: a 216 kHz enable tick arrives from outside, and of every nine ticks the block forwards eight. This gives an average of 192 kHz, or 24 bits per 125 µs frame.

Each forwarded tick also samples the serial input. The samples are gathered most significant bit first into 24-bit words. A completed word moves into a hold register only when a frame starts, so the three bytes of one frame always come from a single word. When the insert enable is high, the three DCC byte positions of the outgoing frame carry the held word. When it is low, and at every other position, the stream passes through unchanged. All outputs are registered.

Top module: `dcc_serial_inserter`

## Requirements
- R1: Each forwarded tick samples `dcc_bit` on the same clock edge and raises `dcc_clk` for exactly the following cycle.
- R2: Ticks are counted from reset in groups of nine. The ninth tick of every group produces no `dcc_clk` pulse and takes no sample.
- R3: Samples are packed most significant bit first. Within a word, samples 1 to 8 form the first DCC byte (bit 7 down to bit 0), samples 9 to 16 form the second, and samples 17 to 24 form the third.
- R4: Sample counting starts at reset, and every 24 consecutive samples complete one word. There is no other alignment.
- R5: On the cycle a valid start-of-frame byte is accepted, the hold register takes the last word that was complete before that cycle. At all other times it stays unchanged. It reads zero until the first transfer of a completed word.
- R6: Byte positions are counted from the start-of-frame byte, which is position 0, in rows of 270 bytes. Row index 2 at column indices 0, 3 and 6 holds DCC bytes 1, 2 and 3. When `ins_en` is high in the cycle such a byte is input, the output carries the matching held byte.
- R7: When `ins_en` is low, and at all positions other than those in R6, `out_data` equals the input byte.
- R8: `out_valid`, `out_sof` (valid and start of frame) and `out_data` follow the input one cycle later. `out_data` is zero on invalid cycles. Invalid cycles do not advance the byte position.
- R9: After reset, `dcc_clk`, `out_valid`, `out_sof` and `out_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_216 | input | 1 | One-cycle enable at the 216 kHz rate |
| dcc_bit | input | 1 | Serial DCC data from upstream |
| ins_en | input | 1 | Insert enable |
| in_valid | input | 1 | Input byte qualifier |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_data | input | 8 | Input byte |
| dcc_clk | output | 1 | Gapped strobe for the upstream source |
| out_valid | output | 1 | Output byte qualifier |
| out_sof | output | 1 | Output start of frame |
| out_data | output | 8 | Output byte |

## Verification
A wrong tick phase shows up at `dcc_clk` within nine ticks, as a pulse missing or present in the wrong place. A slip in the sample count or bit order corrupts the DCC bytes of the next frame that has insertion enabled. A position counter that drifts shows as a DCC byte replaced at a wrong offset, or as a substitution that is missing, in row 2 of the same frame. The bench models ticks, samples, words and positions behaviourally and compares all four outputs on every clock. It keeps the tick rate high so that many words complete within each frame, and it varies the enable and the valid gaps.

// File: rtl/dcc_ins_pkg.sv
package dcc_ins_pkg;
  typedef enum logic [1:0] {
    SLOT_D1   = 2'd0,
    SLOT_D2   = 2'd1,
    SLOT_D3   = 2'd2,
    SLOT_NONE = 2'd3
  } dslot_e;

  localparam int unsigned DCC_BYTES = 3;
endpackage

// File: rtl/dcc_gap_clock.sv
module dcc_gap_clock #(
  parameter int unsigned GROUP = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic sample_o,
  output logic strobe_o
);
  localparam int unsigned PW = (GROUP > 1) ? $clog2(GROUP) : 1;
  localparam logic [PW-1:0] LAST = PW'(GROUP - 1);

  logic [PW-1:0] phase_q;
  logic          strobe_q;

  assign sample_o = tick_i && (phase_q != LAST);
  assign strobe_o = strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= sample_o;
      if (tick_i) phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end

  p_strobe_after_tick_r1: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> $past(tick_i));
  p_gap_suppressed_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_i && phase_q == LAST) |=> !strobe_q);
  p_phase_range_r2: assert property (@(posedge clk) disable iff (rst)
    phase_q <= LAST);
endmodule

// File: rtl/dcc_bit_packer.sv
module dcc_bit_packer #(
  parameter int unsigned WORD_BITS = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_i,
  input  logic                 bit_i,
  input  logic                 frame_i,
  output logic [WORD_BITS-1:0] hold_o
);
  localparam int unsigned CW = $clog2(WORD_BITS);
  localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);

  logic [WORD_BITS-2:0] shift_q;
  logic [CW-1:0]        cnt_q;
  logic [WORD_BITS-1:0] done_q;
  logic [WORD_BITS-1:0] hold_q;

  assign hold_o = hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      cnt_q   <= '0;
      done_q  <= '0;
    end else if (sample_i) begin
      if (cnt_q == LAST) begin
        done_q  <= {shift_q, bit_i};
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
      shift_q <= {shift_q[WORD_BITS-3:0], bit_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          hold_q <= '0;
    else if (frame_i) hold_q <= done_q;
  end

  p_count_range_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  p_hold_only_at_frame_r5: assert property (@(posedge clk) disable iff (rst)
    !frame_i |=> $stable(hold_q));
  p_done_only_on_sample_r4: assert property (@(posedge clk) disable iff (rst)
    !sample_i |=> $stable(done_q));
endmodule

// File: rtl/dcc_slot_locator.sv
module dcc_slot_locator
  import dcc_ins_pkg::*;
#(
  parameter int unsigned COLS   = 270,
  parameter int unsigned ROWS   = 9,
  parameter int unsigned D_ROW  = 2,
  parameter int unsigned D_COL0 = 0,
  parameter int unsigned D_STEP = 3
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   valid_i,
  input  logic   sof_i,
  output dslot_e slot_o
);
  localparam int unsigned CW = $clog2(COLS);
  localparam int unsigned RW = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [CW-1:0] col_q, cur_col;
  logic [RW-1:0] row_q, cur_row;
  logic [DCC_BYTES-1:0] hit;

  assign cur_col = sof_i ? '0 : col_q;
  assign cur_row = sof_i ? '0 : row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      row_q <= '0;
    end else if (valid_i) begin
      if (cur_col == CW'(COLS - 1)) begin
        col_q <= '0;
        row_q <= (cur_row == RW'(ROWS - 1)) ? '0 : cur_row + 1'b1;
      end else begin
        col_q <= cur_col + 1'b1;
        row_q <= cur_row;
      end
    end
  end

  for (genvar k = 0; k < DCC_BYTES; k++) begin : g_hit
    assign hit[k] = (cur_row == RW'(D_ROW)) &&
                    (cur_col == CW'(D_COL0 + k * D_STEP));
  end

  always_comb begin
    slot_o = SLOT_NONE;
    if (hit[0])      slot_o = SLOT_D1;
    else if (hit[1]) slot_o = SLOT_D2;
    else if (hit[2]) slot_o = SLOT_D3;
  end

  p_col_range_r6: assert property (@(posedge clk) disable iff (rst)
    col_q < CW'(COLS));
  p_row_range_r6: assert property (@(posedge clk) disable iff (rst)
    row_q < RW'(ROWS));
  p_hold_pos_r8: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(col_q) && $stable(row_q)));
endmodule

// File: rtl/dcc_serial_inserter.sv
module dcc_serial_inserter
  import dcc_ins_pkg::*;
#(
  parameter int unsigned GROUP     = 9,
  parameter int unsigned WORD_BITS = 24,
  parameter int unsigned COLS      = 270,
  parameter int unsigned ROWS      = 9,
  parameter int unsigned D_ROW     = 2,
  parameter int unsigned D_COL0    = 0,
  parameter int unsigned D_STEP    = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_216,
  input  logic       dcc_bit,
  input  logic       ins_en,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic [7:0] in_data,
  output logic       dcc_clk,
  output logic       out_valid,
  output logic       out_sof,
  output logic [7:0] out_data
);
  logic                 sample;
  logic [WORD_BITS-1:0] hold;
  dslot_e               slot;
  logic [7:0]           sel_byte;
  logic                 frame_evt;

  assign frame_evt = in_valid && in_sof;

  dcc_gap_clock #(.GROUP(GROUP)) u_gap (
    .clk(clk), .rst(rst), .tick_i(tick_216),
    .sample_o(sample), .strobe_o(dcc_clk)
  );

  dcc_bit_packer #(.WORD_BITS(WORD_BITS)) u_pack (
    .clk(clk), .rst(rst), .sample_i(sample), .bit_i(dcc_bit),
    .frame_i(frame_evt), .hold_o(hold)
  );

  dcc_slot_locator #(
    .COLS(COLS), .ROWS(ROWS), .D_ROW(D_ROW), .D_COL0(D_COL0), .D_STEP(D_STEP)
  ) u_loc (
    .clk(clk), .rst(rst), .valid_i(in_valid), .sof_i(in_sof), .slot_o(slot)
  );

  always_comb begin
    case (slot)
      SLOT_D1: sel_byte = hold[WORD_BITS-1 -: 8];
      SLOT_D2: sel_byte = hold[WORD_BITS-9 -: 8];
      SLOT_D3: sel_byte = hold[WORD_BITS-17 -: 8];
      default: sel_byte = in_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_data  <= 8'h00;
    end else begin
      out_valid <= in_valid;
      out_sof   <= frame_evt;
      if (!in_valid)   out_data <= 8'h00;
      else if (ins_en) out_data <= sel_byte;
      else             out_data <= in_data;
    end
  end

  p_valid_latency_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && out_data == 8'h00));
  p_passthru_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ins_en) |=> out_data == $past(in_data));
  p_other_pos_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && slot == SLOT_NONE) |=> out_data == $past(in_data));
endmodule

// File: tb/tb_dcc_serial_inserter.sv
module tb_dcc_serial_inserter;
  localparam int CLK_PERIOD = 10;
  localparam int COLS = 270;
  localparam int ROWS = 9;
  localparam int FRAME = COLS * ROWS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_216 = 1'b0, dcc_bit = 1'b0, ins_en = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic dcc_clk, out_valid, out_sof;
  logic [7:0] out_data;

  int compared = 0, mismatched = 0;

  dcc_serial_inserter dut (
    .clk(clk), .rst(rst), .tick_216(tick_216), .dcc_bit(dcc_bit),
    .ins_en(ins_en), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .dcc_clk(dcc_clk), .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int  m_ticks, m_nbits, m_pos;
  logic [23:0] m_acc, m_done, m_hold;
  logic e_clk, e_valid, e_sof;
  logic [7:0] e_data;

  always @(posedge clk) begin
    if (rst) begin
      m_ticks = 0; m_nbits = 0; m_pos = 0;
      m_acc = '0; m_done = '0; m_hold = '0;
      e_clk = 0; e_valid = 0; e_sof = 0; e_data = 8'h00;
    end else begin
      logic [23:0] old_done, old_hold;
      int p, r, c, k;
      old_done = m_done;
      old_hold = m_hold;
      e_clk = 1'b0;
      if (tick_216) begin
        if (m_ticks % 9 != 8) begin           // R1, R2
          e_clk = 1'b1;
          m_acc = {m_acc[22:0], dcc_bit};     // R3 MSB first
          m_nbits++;
          if (m_nbits == 24) begin            // R4
            m_done = m_acc; m_nbits = 0; m_acc = '0;
          end
        end
        m_ticks++;
      end
      e_valid = in_valid;
      e_sof   = in_valid && in_sof;
      e_data  = 8'h00;
      if (in_valid) begin
        p = in_sof ? 0 : m_pos;
        r = p / COLS; c = p % COLS;
        k = -1;
        if (r == 2 && (c == 0 || c == 3 || c == 6)) k = c / 3;   // R6
        if (ins_en && k >= 0) e_data = old_hold[23 - 8*k -: 8];
        else                  e_data = in_data;                  // R7
        m_pos = (p + 1) % FRAME;
        if (in_sof) m_hold = old_done;                           // R5
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic s, input logic [7:0] d,
                      input logic en, input logic tk);
    @(negedge clk);
    check("R1/R2 dcc_clk", {7'd0, dcc_clk}, {7'd0, e_clk});
    check("R8 out_valid", {7'd0, out_valid}, {7'd0, e_valid});
    check("R8 out_sof", {7'd0, out_sof}, {7'd0, e_sof});
    check("R3/R4/R5/R6/R7 out_data", out_data, e_data);
    in_valid = v; in_sof = s; in_data = d; ins_en = en; tick_216 = tk;
    dcc_bit = 1'($urandom);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    int cyc;
    cyc = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state visible at the ports
    check("R9 dcc_clk", {7'd0, dcc_clk}, 8'd0);
    check("R9 out_valid", {7'd0, out_valid}, 8'd0);
    check("R9 out_sof", {7'd0, out_sof}, 8'd0);
    check("R9 out_data", out_data, 8'd0);
    for (int f = 0; f < 8; f++) begin
      for (int b = 0; b < FRAME; b++) begin
        logic en;
        if (f < 3)       en = 1'b1;
        else if (f == 3) en = 1'b0;
        else             en = 1'($urandom);
        if (f >= 2 && ($urandom % 10) == 0)
          step(1'b0, 1'($urandom), 8'($urandom), en, (cyc % 7) == 0) ; // R8 gaps
        else begin
          step(1'b1, b == 0, 8'($urandom), en, (cyc % 7) == 0);
          cyc++;
          continue;
        end
        cyc++;
        b--;
      end
    end
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule